// File: doc/BRIEF.md
# Reload-and-compare PWM timer

This block is a free-running up-counter that turns two counter events into one pulse-width-modulated output. When the count passes its all-ones value it does not return to zero: it reloads from a programmable start value, and the output goes to its active level. When the count equals a programmable compare value, the output goes back to its inactive level. The distance of the start value below all-ones sets the period. The distance of the compare value above the start value sets the active time.

Software drives the block through a flat write port and a read port. It sets the start value and the compare value. It can preload the counter, for example to all-ones minus one, so that the first active edge comes within two counting steps. It then sets the run bit. A polarity bit swaps the active and inactive levels, and it is accepted only while the timer is stopped. An optional clock-enable divider slows the counting rate. None of the settings is shadowed: a write acts on the running period at once.

Top module: `lmp_pwm_timer`

## Requirements
- R1: A synchronous active-high `rst` clears all settings. After reset the timer is stopped, the counter is 0, polarity is normal, the divider is off and `pwm_out` is 0.
- R2: The write map, selected by `wr_addr`, is as follows. Address 0 is control: bit 0 is run and bit 1 is invert. Address 1 is the start (reload) value and address 2 is the compare value. Address 3 writes the counter directly. Address 4 is the divider: bit 3 enables it and bits 2:0 are its exponent field. On each counting step the count goes up by one. A step taken at all-ones makes the next count equal to the start value.
- R3: A counting step taken at all-ones makes the output active from the next cycle. A step taken when the count equals the compare value makes it inactive from the next cycle. One period therefore lasts (all-ones − start + 1) steps, of which (compare − start + 1) are active.
- R4: When start and compare are both all-ones minus one, the output toggles on every step: the period is 2 steps and the active time is 1 step.
- R5: Writing run = 0 freezes the counter at its present value from the next cycle, without finishing the period. While stopped, the output shows the inactive level.
- R6: `pwm_out` is the internal active level XOR invert, and it equals invert while stopped. A control write changes invert only if the timer was stopped before that write. While running, the invert bit of a control write is ignored.
- R7: With the divider disabled, a counting step occurs on every clock while running. With it enabled and field f, a step occurs once every 2^(f+1) clocks. The divider phase restarts while stopped and on every divider write, so the first step comes 2^(f+1) clocks later.
- R8: When a step is taken at a count that equals both the compare value and all-ones, the compare wins and the output becomes inactive.
- R9: Writes to the start and compare values act immediately on the running period, with no buffering.
- R10: A counter write loads the written value in the next cycle. It takes priority over a counting step in the same cycle, and that step produces no event.
- R11: Reading `rd_addr` 0 returns status: bit 0 is run, bit 1 is invert, bit 2 is the present `pwm_out`, and the other bits are 0. Reading `rd_addr` 3 returns the live counter. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read select (0 status, 3 counter) |
| rd_data | output | 32 | Read data, combinational from state |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
The hardest situations to reach are collisions. One is a compare value equal to all-ones, so that the compare and the overflow fall on the same step. Another is a counter write landing on a counting step. The stimulus forces the first by setting the compare value to all-ones with a short period. It forces the second by writing the counter repeatedly while the divider is off, so that every write collides with a step. A third case is an attempted polarity change while running. The stimulus follows that write with a stop, so that the retained invert level becomes visible on `pwm_out`. A behavioural model in the bench is compared with both outputs on every clock, and duty is measured over whole periods.

// File: rtl/lmp_pkg.sv
package lmp_pkg;
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_MATCH = 3'd2,
        A_COUNT = 3'd3,
        A_PRESC = 3'd4
    } reg_addr_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_INV_BIT = 1;
endpackage

// File: rtl/lmp_regs.sv
module lmp_regs
    import lmp_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             run,
    output logic             inv,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] match_val,
    output logic             ps_en,
    output logic [PS_W-1:0]  ps_sel,
    output logic             cnt_wr,
    output logic             ps_wr
);
    typedef struct packed {
        logic             run;
        logic             inv;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
        logic             ps_en;
        logic [PS_W-1:0]  ps_sel;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    s_d.run = wr_data[CTRL_RUN_BIT];
                    // polarity may only move while the timer is idle
                    if (!s_q.run) s_d.inv = wr_data[CTRL_INV_BIT];
                end
                A_LOAD:  s_d.load  = wr_data;
                A_MATCH: s_d.match = wr_data;
                A_PRESC: begin
                    s_d.ps_en  = wr_data[PS_W];
                    s_d.ps_sel = wr_data[PS_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign run       = s_q.run;
    assign inv       = s_q.inv;
    assign load_val  = s_q.load;
    assign match_val = s_q.match;
    assign ps_en     = s_q.ps_en;
    assign ps_sel    = s_q.ps_sel;
    assign cnt_wr    = wr_en && (wr_addr == A_COUNT);
    assign ps_wr     = wr_en && (wr_addr == A_PRESC);
endmodule

// File: rtl/lmp_prescaler.sv
module lmp_prescaler #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            ps_en,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            ps_wr,
    output logic            tick
);
    localparam int unsigned DIV_W = 1 << PS_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t s_d, s_q;
    logic [PS_W:0]    shamt;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] lim;

    assign shamt = {1'b0, ps_sel} + (PS_W+1)'(1);
    assign span  = (DIV_W+1)'(1) << shamt;
    assign lim   = ps_en ? DIV_W'(span - (DIV_W+1)'(1)) : '0;
    assign tick  = run && (s_q.div == lim);

    always_comb begin
        s_d = s_q;
        if (!run || ps_wr || tick) s_d.div = '0;
        else                       s_d.div = s_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/lmp_counter.sv
module lmp_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_ev,
    output logic             cmp_ev
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic at_top;
    logic step;

    always_comb begin
        s_d    = s_q;
        at_top = (s_q.cnt == '1);
        step   = tick && !cnt_wr;
        ovf_ev = step && at_top;
        cmp_ev = step && (s_q.cnt == match_val);
        if (cnt_wr)    s_d.cnt = cnt_wdata;
        else if (tick) s_d.cnt = at_top ? load_val : s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/lmp_wave.sv
module lmp_wave (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic inv,
    input  logic ovf_ev,
    input  logic cmp_ev,
    output logic level,
    output logic pwm_out
);
    typedef struct packed {
        logic level;
    } wave_t;

    wave_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run)        s_d.level = 1'b0;
        else if (cmp_ev) s_d.level = 1'b0;   // compare outranks overflow
        else if (ovf_ev) s_d.level = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign level   = s_q.level;
    assign pwm_out = (s_q.level & run) ^ inv;
endmodule

// File: rtl/lmp_pwm_timer.sv
module lmp_pwm_timer
    import lmp_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out
);
    logic             run, inv, ps_en, cnt_wr, ps_wr, tick;
    logic             ovf_ev, cmp_ev, level;
    logic [PS_W-1:0]  ps_sel;
    logic [CNT_W-1:0] load_val, match_val, cnt;

    lmp_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .inv(inv), .load_val(load_val),
        .match_val(match_val), .ps_en(ps_en), .ps_sel(ps_sel),
        .cnt_wr(cnt_wr), .ps_wr(ps_wr)
    );

    lmp_prescaler #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .ps_en(ps_en),
        .ps_sel(ps_sel), .ps_wr(ps_wr), .tick(tick)
    );

    lmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
        .cnt_wdata(wr_data), .load_val(load_val), .match_val(match_val),
        .cnt(cnt), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev)
    );

    lmp_wave u_wave (
        .clk(clk), .rst(rst), .run(run), .inv(inv), .ovf_ev(ovf_ev),
        .cmp_ev(cmp_ev), .level(level), .pwm_out(pwm_out)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_CTRL:  rd_data = {{(CNT_W-3){1'b0}}, pwm_out, inv, run};
            A_COUNT: rd_data = cnt;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lmp_checks.sv
module lmp_checks #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             inv,
    input logic             tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] match_val,
    input logic             level,
    input logic             pwm_out
);
    a_r2_wrap_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == '1) |=> (cnt == $past(load_val)));

    a_r3_overflow_rise: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == '1 && match_val != '1) |=> level);

    a_r5_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == inv));

    a_r6_inv_locked: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(inv));

    a_r8_match_first: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == match_val) |=> !level);

    a_r10_direct_load: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(cnt_wdata)));
endmodule

bind lmp_pwm_timer lmp_checks #(.CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst(rst), .run(run), .inv(inv), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data), .cnt(cnt), .load_val(load_val),
    .match_val(match_val), .level(level), .pwm_out(pwm_out)
);

// File: tb/lmp_pwm_timer_bench.sv
module lmp_pwm_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    lmp_pwm_timer u_lmp_pwm_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit          m_run, m_inv, m_level, m_pen;
    int          m_pf, m_div;
    logic [31:0] m_cnt, m_load, m_match;

    always @(posedge clk) begin
        int  lim;
        bit  tk, cw, cmp, ovf, old_run;
        if (rst) begin
            m_run = 0; m_inv = 0; m_level = 0; m_pen = 0; m_pf = 0; m_div = 0;
            m_cnt = 0; m_load = 0; m_match = 0;
        end else begin
            lim = m_pen ? ((1 << (m_pf + 1)) - 1) : 0;
            tk  = m_run && (m_div == lim);
            cw  = wr_en && (wr_addr == 3'd3);
            cmp = tk && !cw && (m_cnt == m_match);
            ovf = tk && !cw && (m_cnt == MAXV);
            old_run = m_run;
            if (!m_run || (wr_en && wr_addr == 3'd4) || tk) m_div = 0;
            else m_div = m_div + 1;
            if (!m_run || cmp) m_level = 0;
            else if (ovf) m_level = 1;
            if (cw) m_cnt = wr_data;
            else if (tk) m_cnt = (m_cnt == MAXV) ? m_load : m_cnt + 1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_run = wr_data[0];
                        if (!old_run) m_inv = wr_data[1];
                    end
                    3'd1: m_load = wr_data;
                    3'd2: m_match = wr_data;
                    3'd4: begin m_pen = wr_data[3]; m_pf = int'(wr_data[2:0]); end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare every clock, a quarter period after the falling edge
    always begin
        logic [31:0] exp_rd;
        bit          exp_out;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst && !done) begin
            exp_out = (m_level & m_run) ^ m_inv;
            if (rd_addr == 3'd0) exp_rd = {29'd0, exp_out, m_inv, m_run};
            else                 exp_rd = m_cnt;
            check({cur_req, " pwm_out"}, longint'(pwm_out), longint'(exp_out));
            check({"R11 rd_data (", cur_req, ")"}, longint'(rd_data), longint'(exp_rd));
            rd_addr = (rd_addr == 3'd0) ? 3'd3 : 3'd0;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_high(string req, int n, int exp);
        int hi;
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (pwm_out) hi++;
        end
        check(req, hi, exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        idle(3);
        check("R1 reset output", longint'(pwm_out), 0);

        cur_req = "R2";
        wr(3'd1, MAXV - 9);
        wr(3'd2, MAXV - 5);
        cur_req = "R10";
        wr(3'd3, MAXV - 1);
        cur_req = "R3";
        wr(3'd0, 32'h1);
        idle(10);
        measure_high("R3 duty 5 of 10", 20, 10);

        cur_req = "R9";
        wr(3'd2, MAXV - 2);
        idle(30);
        wr(3'd1, MAXV - 13);
        idle(30);

        cur_req = "R10";
        for (int i = 0; i < 6; i++) begin
            wr(3'd3, MAXV - 3);
            idle(2);
        end
        wr(3'd3, MAXV);
        idle(12);

        cur_req = "R5";
        wr(3'd0, 32'h0);
        idle(6);
        check("R5 stopped output", longint'(pwm_out), 0);

        cur_req = "R6";
        wr(3'd0, 32'h3);
        idle(20);
        wr(3'd0, 32'h1);
        idle(5);
        wr(3'd0, 32'h0);
        idle(2);
        check("R6 invert kept while stopped", longint'(pwm_out), 1);
        wr(3'd0, 32'h0);
        idle(2);
        check("R6 invert cleared when idle", longint'(pwm_out), 0);

        cur_req = "R4";
        wr(3'd1, MAXV - 1);
        wr(3'd2, MAXV - 1);
        wr(3'd3, MAXV - 1);
        wr(3'd0, 32'h1);
        idle(4);
        measure_high("R4 toggle every step", 20, 10);

        cur_req = "R7";
        wr(3'd1, MAXV - 9);
        wr(3'd2, MAXV - 5);
        wr(3'd4, 32'h9);
        idle(60);
        measure_high("R7 divide by 4", 80, 40);
        wr(3'd4, 32'hF);
        idle(700);
        wr(3'd4, 32'h8);
        idle(30);
        wr(3'd4, 32'h0);
        idle(10);

        cur_req = "R8";
        wr(3'd1, MAXV - 3);
        wr(3'd2, MAXV);
        idle(20);
        measure_high("R8 compare beats overflow", 20, 0);

        cur_req = "R1";
        wr(3'd2, MAXV - 2);
        idle(7);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(1);
        check("R1 reset mid-run output", longint'(pwm_out), 0);
        idle(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule